// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates among five interrupt sources on behalf of a processor core: two active-low external pins, two timer overflow flags (set by one-cycle pulses from timers outside the block), and a serial source that is the OR of a receive flag and a transmit flag. Each source has an individual enable bit, a global enable bit gates them all, and a priority bit places each source in the high or the low level. Each external pin has a trigger-type bit that selects falling-edge or low-level sensing. Pins pass through a two-flop synchronizer and are then sampled once per machine cycle of `MC_CLKS` clocks.

At every instruction boundary reported by the core, the block may grant one source. It then holds a request and a vector address until the core acknowledges. On acknowledge it records the granted level in a two-entry in-service stack and clears the timer or edge flag it granted. A return-from-interrupt pulse pops the highest active level. The first instruction boundary after that pulse is skipped, so the interrupted program always makes progress.

The control state machine has three states. `S_IDLE` waits for a boundary. It moves to `S_REQ` (transition *grant*) when a boundary arrives with an eligible source, and to `S_HOLD` (transition *return*) when a return pulse arrives. `S_REQ` drives the request and returns to `S_IDLE` on acknowledge (transition *accept*). `S_HOLD` goes back to `S_IDLE` at the next boundary (transition *resume*).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `in_svc` is 0, all enables are cleared and no pending flag is set. A timer flag raised while the enables are cleared yields no request.
- R2: A source is eligible only when its own enable bit and the global bit 7 of the enable word are both 1. The enable bits are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial. Bits 6 and 5 have no function.
- R3: The vector is 0x0003 + 8 × source index, with index 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial (0x0003, 0x000B, 0x0013, 0x001B, 0x0023).
- R4: Among eligible sources of the same level, the lowest index is granted first.
- R5: A priority bit of 1 (same bit positions as the enables) makes a source high level, and an eligible high source is granted before any low source.
- R6: While a high handler is in service nothing is granted. While only a low handler is in service only high sources are granted. A low source is granted only when `in_svc` is 0. `in_svc` bit 1 marks high in service and bit 0 marks low in service.
- R7: With the trigger bit of a pin at 1, a falling edge on the pin sets its pending flag, and the flag stays set after the pin returns high.
- R8: With the trigger bit at 0, the pin's pending flag follows the sampled low level. An acknowledge does not clear it, so it is granted again while the pin stays low.
- R9: Acknowledging a timer source or an edge-mode external source clears that flag. Serial flags are never cleared by the block.
- R10: `reti` clears the highest set bit of `in_svc`. The first `insn_done` after `reti` grants nothing, and arbitration resumes at the next one.
- R11: Grants happen only on `insn_done`. A granted request and its vector stay unchanged until `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer 0, bit 1 timer 1) |
| ser_rx_flag | input | 1 | Serial receive-complete flag |
| ser_tx_flag | input | 1 | Serial transmit-complete flag |
| en_we | input | 1 | Enable word write strobe |
| en_wdata | input | 8 | Enable word (bit 7 global) |
| pri_we | input | 1 | Priority word write strobe |
| pri_wdata | input | 5 | Priority bits, 1 = high |
| trig_we | input | 1 | Trigger-type write strobe |
| trig_wdata | input | 2 | Per-pin trigger type, 1 = falling edge |
| insn_done | input | 1 | Instruction boundary pulse from the core |
| irq_ack | input | 1 | Core accepts the pending request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address for the request |
| in_svc | output | 2 | In-service levels (bit 1 high, bit 0 low) |
| flag_pend | output | 5 | Pending flags by source index, before enables |

## Verification
The arbitration is tried with several simultaneous timer and serial patterns inside one level, which separates the fixed order from the priority override. The same sources are then split across levels while a handler of each level is in service, which tells the three nesting rules apart. Both pins are driven as a short falling pulse in edge mode and as a sustained low in level mode, which shows the difference between a latched flag that the acknowledge clears and a level that survives the acknowledge. Boundary-free waits and the boundary directly after a return show that grants are tied to instruction boundaries.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_SRC = 5;
    localparam int N_EXT = 2;
    localparam int IDX_W = $clog2(N_SRC);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_HOLD = 2'd2
    } arb_state_t;

    // lowest set index wins (fixed polling order)
    function automatic logic [IDX_W-1:0] first_set(input logic [N_SRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic mc_tick,
    output logic fall,
    output logic low_lvl
);
    logic s1_q, s2_q, samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            samp_q <= 1'b1;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
            if (mc_tick) samp_q <= s2_q;
        end
    end

    assign fall    = mc_tick & samp_q & ~s2_q;
    assign low_lvl = ~samp_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] fall,
    input  logic [N_EXT-1:0] low_lvl,
    input  logic [N_EXT-1:0] trig,
    input  logic [N_EXT-1:0] tmr_ovf,
    input  logic             ser_rx,
    input  logic             ser_tx,
    input  logic             clr_vld,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N_SRC-1:0] pend
);
    for (genvar g = 0; g < N_EXT; g++) begin : g_pair
        logic eflag_q, tflag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                eflag_q <= 1'b0;
                tflag_q <= 1'b0;
            end else begin
                if (trig[g] && fall[g])                          eflag_q <= 1'b1;
                else if (clr_vld && clr_idx == IDX_W'(2*g))      eflag_q <= 1'b0;
                if (tmr_ovf[g])                                  tflag_q <= 1'b1;
                else if (clr_vld && clr_idx == IDX_W'(2*g + 1))  tflag_q <= 1'b0;
            end
        end

        assign pend[2*g]     = trig[g] ? eflag_q : low_lvl[g];
        assign pend[2*g + 1] = tflag_q;
    end

    assign pend[N_SRC-1] = ser_rx | ser_tx;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic [N_SRC-1:0] active,
    input  logic [N_SRC-1:0] pri,
    input  logic [1:0]       in_svc,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    logic [N_SRC-1:0] hi_c, lo_c;

    assign hi_c = active & pri;
    assign lo_c = active & ~pri;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        hi    = 1'b0;
        if (!in_svc[1]) begin
            if (|hi_c) begin
                valid = 1'b1;
                hi    = 1'b1;
                idx   = first_set(hi_c);
            end else if (in_svc == 2'b00 && |lo_c) begin
                valid = 1'b1;
                idx   = first_set(lo_c);
            end
        end
    end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       push_hi,
    input  logic       pop,
    output logic [1:0] in_svc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_svc <= 2'b00;
        end else if (push) begin
            if (push_hi) in_svc[1] <= 1'b1;
            else         in_svc[0] <= 1'b1;
        end else if (pop) begin
            if (in_svc[1]) in_svc[1] <= 1'b0;
            else           in_svc[0] <= 1'b0;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int MC_CLKS    = 12,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_n,
    input  logic [N_EXT-1:0] tmr_ovf,
    input  logic             ser_rx_flag,
    input  logic             ser_tx_flag,
    input  logic             en_we,
    input  logic [7:0]       en_wdata,
    input  logic             pri_we,
    input  logic [N_SRC-1:0] pri_wdata,
    input  logic             trig_we,
    input  logic [N_EXT-1:0] trig_wdata,
    input  logic             insn_done,
    input  logic             irq_ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [1:0]       in_svc,
    output logic [N_SRC-1:0] flag_pend
);
    localparam int MC_W = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;

    logic             en_glob_q;
    logic [N_SRC-1:0] en_src_q, pri_q;
    logic [N_EXT-1:0] trig_q;
    logic             unused_en_bits;

    assign unused_en_bits = ^en_wdata[6:N_SRC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_glob_q <= 1'b0;
            en_src_q  <= '0;
            pri_q     <= '0;
            trig_q    <= '0;
        end else begin
            if (en_we) begin
                en_glob_q <= en_wdata[7];
                en_src_q  <= en_wdata[N_SRC-1:0];
            end
            if (pri_we)  pri_q  <= pri_wdata;
            if (trig_we) trig_q <= trig_wdata;
        end
    end

    // machine-cycle sampling tick
    logic [MC_W-1:0] mc_cnt_q;
    logic            mc_tick;

    assign mc_tick = (mc_cnt_q == MC_W'(MC_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mc_cnt_q <= '0;
        else if (mc_tick) mc_cnt_q <= '0;
        else              mc_cnt_q <= mc_cnt_q + 1'b1;
    end

    logic [N_EXT-1:0] pin_fall, pin_low;

    for (genvar p = 0; p < N_EXT; p++) begin : g_pin
        irq_pin_front i_front (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (ext_n[p]),
            .mc_tick (mc_tick),
            .fall    (pin_fall[p]),
            .low_lvl (pin_low[p])
        );
    end

    arb_state_t       state_q, state_d;
    logic [IDX_W-1:0] lat_idx_q;
    logic             lat_hi_q;
    logic             accept;
    logic             pick_vld, pick_hi;
    logic [IDX_W-1:0] pick_idx;
    logic [N_SRC-1:0] active;

    assign accept = (state_q == S_REQ) && irq_ack;

    irq_flag_bank i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (pin_fall),
        .low_lvl (pin_low),
        .trig    (trig_q),
        .tmr_ovf (tmr_ovf),
        .ser_rx  (ser_rx_flag),
        .ser_tx  (ser_tx_flag),
        .clr_vld (accept),
        .clr_idx (lat_idx_q),
        .pend    (flag_pend)
    );

    assign active = flag_pend & en_src_q & {N_SRC{en_glob_q}};

    irq_pick i_pick (
        .active (active),
        .pri    (pri_q),
        .in_svc (in_svc),
        .valid  (pick_vld),
        .idx    (pick_idx),
        .hi     (pick_hi)
    );

    irq_nest i_nest (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (accept),
        .push_hi (lat_hi_q),
        .pop     (reti),
        .in_svc  (in_svc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            lat_idx_q <= '0;
            lat_hi_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && state_d == S_REQ) begin
                lat_idx_q <= pick_idx;
                lat_hi_q  <= pick_hi;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (reti)                       state_d = S_HOLD;
                else if (insn_done && pick_vld) state_d = S_REQ;
            end
            S_REQ: begin
                if (irq_ack) state_d = S_IDLE;
            end
            S_HOLD: begin
                if (insn_done && !reti) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        if (state_q == S_REQ) begin
            irq_req = 1'b1;
            irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(lat_idx_q);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_req,
    input logic        irq_ack,
    input logic        reti,
    input logic [15:0] irq_vec,
    input logic [1:0]  in_svc
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    // R3
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == 16'h0003 || irq_vec == 16'h000B || irq_vec == 16'h0013 ||
                     irq_vec == 16'h001B || irq_vec == 16'h0023));

    // R6
    hi_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(in_svc[1]));

    // R6
    lo_only_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && in_svc[0]) |=> in_svc[1]);

    // R10
    reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !irq_ack && in_svc == 2'b11) |=> (in_svc == 2'b01));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .reti    (reti),
    .irq_vec (irq_vec),
    .in_svc  (in_svc)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
    logic        en_we = 1'b0, pri_we = 1'b0, trig_we = 1'b0;
    logic [7:0]  en_wdata = '0;
    logic [4:0]  pri_wdata = '0;
    logic [1:0]  trig_wdata = '0;
    logic        insn_done = 1'b0, irq_ack = 1'b0, reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  in_svc;
    logic [4:0]  flag_pend;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] exp_vec[$];
    string       exp_tag[$];

    always #4 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
        .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
        .en_we(en_we), .en_wdata(en_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
        .trig_we(trig_we), .trig_wdata(trig_wdata), .insn_done(insn_done),
        .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
        .in_svc(in_svc), .flag_pend(flag_pend)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_vec(input logic [15:0] v, input string tag);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
    endtask

    // monitor: acts as the core, accepts every request and scores it
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (irq_ack) begin
                irq_ack = 1'b0;
            end else if (irq_req) begin
                n_chk++;
                if (exp_vec.size() == 0) begin
                    n_bad++;
                    $display("FAIL R6 R10 R11 unexpected request act=%0h exp=none", irq_vec);
                end else begin
                    logic [15:0] ev;
                    string       et;
                    ev = exp_vec.pop_front();
                    et = exp_tag.pop_front();
                    if (irq_vec !== ev) begin
                        n_bad++;
                        $display("FAIL %s vector act=%0h exp=%0h", et, irq_vec, ev);
                    end
                end
                irq_ack = 1'b1;
            end
        end
    end

    task automatic step(input string tag);
        @(negedge clk) insn_done = 1'b1;
        @(negedge clk) insn_done = 1'b0;
        repeat (4) @(negedge clk);
        chk(exp_vec.size(), 0, tag);
    endtask

    task automatic do_reti();
        @(negedge clk) reti = 1'b1;
        @(negedge clk) reti = 1'b0;
    endtask

    task automatic wr_en(input logic [7:0] d);
        @(negedge clk) begin en_we = 1'b1; en_wdata = d; end
        @(negedge clk) en_we = 1'b0;
    endtask

    task automatic wr_pri(input logic [4:0] d);
        @(negedge clk) begin pri_we = 1'b1; pri_wdata = d; end
        @(negedge clk) pri_we = 1'b0;
    endtask

    task automatic wr_trig(input logic [1:0] d);
        @(negedge clk) begin trig_we = 1'b1; trig_wdata = d; end
        @(negedge clk) trig_we = 1'b0;
    endtask

    task automatic tmr_pulse(input logic [1:0] m);
        @(negedge clk) tmr_ovf = m;
        @(negedge clk) tmr_ovf = 2'b00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq_req, 0, "R1 req");
        chk(in_svc, 0, "R1 in_svc");
        chk(flag_pend, 0, "R1 flags");
        tmr_pulse(2'b01);
        chk(flag_pend[1], 1, "R1 timer flag raised");
        step("R1 no grant with enables cleared");
        chk(irq_req, 0, "R1 req stays low");

        // R2 both enable bits needed
        wr_en(8'h80);
        step("R2 global only");
        wr_en(8'h02);
        step("R2 source only");
        wr_en(8'h82);
        expect_vec(16'h000B, "R3 timer0 vector");
        step("R2 both bits grant");
        chk(in_svc, 2'b01, "R6 low in service");
        chk(flag_pend[1], 0, "R9 timer flag cleared");
        do_reti();
        chk(in_svc, 2'b00, "R10 pop low");
        step("R10 hold boundary");

        // R4 fixed order within low level
        wr_en(8'h9F);
        tmr_pulse(2'b11);
        @(negedge clk) ser_rx_flag = 1'b1;
        expect_vec(16'h000B, "R4 timer0 first");
        step("R4 first grant");
        do_reti();
        step("R10 skip after return");
        expect_vec(16'h001B, "R4 timer1 second");
        step("R4 second grant");
        do_reti();
        step("R10 skip after return");
        expect_vec(16'h0023, "R4 serial last");
        step("R4 third grant");
        do_reti();
        chk(flag_pend[4], 1, "R9 serial not cleared");
        @(negedge clk) ser_rx_flag = 1'b0;
        step("R10 hold boundary");

        // R5 priority override and R6 high not preempted
        wr_pri(5'h10);
        @(negedge clk) ser_tx_flag = 1'b1;
        tmr_pulse(2'b01);
        expect_vec(16'h0023, "R5 high serial before low timer0");
        step("R5 high grant");
        chk(in_svc, 2'b10, "R6 high in service");
        step("R6 low blocked under high");
        wr_pri(5'h12);
        step("R6 high blocked under high");
        @(negedge clk) ser_tx_flag = 1'b0;
        do_reti();
        chk(in_svc, 2'b00, "R10 pop high");
        step("R10 high pending skipped after return");
        expect_vec(16'h000B, "R5 timer0 as high");
        step("R5 grant after hold");
        chk(in_svc, 2'b10, "R5 high level recorded");
        do_reti();
        step("R10 hold boundary");

        // R6 low preempted only by high
        wr_pri(5'h00);
        tmr_pulse(2'b11);
        expect_vec(16'h000B, "R6 low timer0");
        step("R6 low grant");
        step("R6 low blocked under low");
        wr_pri(5'h08);
        expect_vec(16'h001B, "R6 high timer1 preempts");
        step("R6 preempt grant");
        chk(in_svc, 2'b11, "R6 nested levels");
        do_reti();
        chk(in_svc, 2'b01, "R10 pop highest first");
        do_reti();
        chk(in_svc, 2'b00, "R10 pop low");
        step("R10 hold boundary");

        // R7 edge mode on pin 0
        wr_pri(5'h00);
        wr_en(8'h85);
        wr_trig(2'b01);
        @(negedge clk) ext_n[0] = 1'b0;
        repeat (30) @(negedge clk);
        ext_n[0] = 1'b1;
        repeat (30) @(negedge clk);
        chk(flag_pend[0], 1, "R7 edge latched after release");
        expect_vec(16'h0003, "R7 ext0 vector");
        step("R7 edge grant");
        chk(flag_pend[0], 0, "R9 edge flag cleared");
        do_reti();
        step("R10 hold boundary");

        // R8 level mode on pin 1
        @(negedge clk) ext_n[1] = 1'b0;
        repeat (30) @(negedge clk);
        chk(flag_pend[2], 1, "R8 level seen");
        expect_vec(16'h0013, "R8 ext1 vector");
        step("R8 level grant");
        chk(flag_pend[2], 1, "R8 level not cleared by ack");
        step("R6 low blocked under low");
        do_reti();
        step("R10 skip after return");
        expect_vec(16'h0013, "R8 level granted again");
        step("R8 regrant");
        do_reti();
        @(negedge clk) ext_n[1] = 1'b1;
        repeat (30) @(negedge clk);
        chk(flag_pend[2], 0, "R8 level released");
        step("R10 hold boundary");
        step("R8 no grant after release");

        // R11 no grant without a boundary
        wr_en(8'h82);
        tmr_pulse(2'b01);
        repeat (20) @(negedge clk);
        chk(irq_req, 0, "R11 no boundary no grant");
        expect_vec(16'h000B, "R11 grant at boundary");
        step("R11 boundary grant");
        do_reti();
        step("R10 hold boundary");

        finish_run();
    end
endmodule